// File: doc/BRIEF.md
# Packed-Subword Add Unit

This execution unit adds two operands taken from 32-bit source words. The second operand can also come from a 16-bit immediate. A byte or halfword can be picked out of each source word. Each operand is then widened to 33 bits as signed or unsigned. A two-bit add mode negates one operand or adds one to the sum. The sum is held at 34 bits, so no carry or borrow is lost.

A second stage then works against a third word `srcC`. It can pass the sum through or accumulate `srcC` into it. It can take the minimum or maximum of the sum and `srcC`. It can also write the sum into one halfword or one byte lane of `srcC`, leaving the other bits of `srcC` in place. Optional saturation clamps the result to the signed or unsigned range of the written field. Optional condition codes are produced alongside the result.

The unit takes control fields that are already decoded. It has one register stage: a request presented with `inValid` appears at the outputs one clock later.

Top module: `addsub_unit`

## Requirements
- R1: The unit has one register stage. `outValid` equals `inValid` of the previous cycle. While `rstN` is low, `outValid`, `outRes`, the flags and `outIllegal` are 0.
- R2: The format code is 0=U32, 1=S32, 2=U16, 3=S16, 4=U8, 5=S8, so bit 0 means signed. A halfword format takes bits [15:0] when `sel[0]` is 0 and bits [31:16] when it is 1. A byte format takes byte `sel` (0..3). The selected field is zero- or sign-extended to 33 bits before any negation.
- R3: When `useImm` is 1, operand B is `immVal` in place of `srcB`. It is sign-extended when `fmtB[0]` is 1 and zero-extended otherwise, and only then negated. So a negated 0xFFFF subtracts 1 when signed (adds 1 overall) and subtracts 65535 when unsigned.
- R4: The operation is A+B when no option is set. `negB` gives A−B, `negA` gives B−A, and `plusOne` gives A+B+1. The sum is exact at 34 bits.
- R5: `negA` and `negB` together, or `plusOne` with either negation, is illegal. Such a request sets `outIllegal` and is computed as plain A+B.
- R6: Second-stage code 0 (pass) returns the low 32 bits of the result.
- R7: Codes 1 and 2 write the result's low 16 bits into `srcC[31:16]` and `srcC[15:0]` respectively. Codes 3 and 4 write its low 8 bits into `srcC[7:0]` and `srcC[23:16]` respectively. All other bits of `srcC` are kept.
- R8: Code 5 adds `srcC` to the sum. `srcC` is extended as signed when `dstSigned` is 1 and as unsigned otherwise.
- R9: Codes 6 (min) and 7 (max) compare the 32-bit result with `srcC`. The comparison is signed when `dstSigned` is 1 and unsigned otherwise.
- R10: With `satEn` set, the pre-truncation value is clamped to the field width: 16 bits for codes 1–2, 8 bits for codes 3–4, and 32 bits for the others. The clamp range is signed when `dstSigned` is 1 and unsigned otherwise. Without `satEn`, the value is simply truncated.
- R11: With `ccEn` set, the flags are as follows. `outZero` is 1 when `outRes` is 0. `outNeg` is `outRes[31]`. `outCarry` is 1 when the pre-saturation value lies outside 0..2^32−1. `outOvf` is 1 when it lies outside −2^31..2^31−1. With `ccEn` clear, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present this cycle |
| srcA | input | 32 | First source word |
| srcB | input | 32 | Second source word |
| srcC | input | 32 | Third operand for the second stage |
| immVal | input | 16 | Immediate used for operand B |
| useImm | input | 1 | Take operand B from `immVal` |
| fmtA | input | 3 | Format code of operand A |
| fmtB | input | 3 | Format code of operand B (bit 0 only, in immediate form) |
| selA | input | 2 | Lane select for operand A |
| selB | input | 2 | Lane select for operand B |
| negA | input | 1 | Negate operand A |
| negB | input | 1 | Negate operand B |
| plusOne | input | 1 | Add one to the sum |
| op2Sel | input | 3 | Second-stage operation code |
| satEn | input | 1 | Saturate to the field width |
| dstSigned | input | 1 | Destination is signed |
| ccEn | input | 1 | Produce condition codes |
| outValid | output | 1 | Result valid |
| outRes | output | 32 | Result word |
| outZero | output | 1 | Zero flag |
| outNeg | output | 1 | Sign flag |
| outCarry | output | 1 | Unsigned out-of-range flag |
| outOvf | output | 1 | Signed out-of-range flag |
| outIllegal | output | 1 | Illegal negate/plus-one combination |

## Verification
Some properties are checked on every cycle:
- the one-cycle valid latency;
- that merge operations preserve the untouched bits of `srcC`;
- the ordering that min and max must hold against `srcC`;
- that the flags stay 0 without `ccEn`;
- that a double negation raises `outIllegal`.

The exact arithmetic can only be shown by the bench's scenarios, where a wide-integer model computes the expected word. This covers:
- lane extraction;
- immediate extension ahead of negation, including the ±0xFFFF cases;
- saturation bounds;
- accumulation;
- carry and overflow values.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [2:0] {
    OP_PASS     = 3'd0,
    OP_MRG_HI16 = 3'd1,
    OP_MRG_LO16 = 3'd2,
    OP_MRG_B0   = 3'd3,
    OP_MRG_B2   = 3'd4,
    OP_ACC      = 3'd5,
    OP_MIN      = 3'd6,
    OP_MAX      = 3'd7
  } stage2Op_e;

  typedef enum logic [1:0] {
    AM_ADD   = 2'd0,
    AM_SUB_B = 2'd1,
    AM_SUB_A = 2'd2,
    AM_INC   = 2'd3
  } addMode_e;

  typedef enum logic [1:0] {
    SW_FULL = 2'd0,
    SW_HALF = 2'd1,
    SW_BYTE = 2'd2
  } satWidth_e;

  // strobes from control to datapath
  typedef struct packed {
    addMode_e  addMode;
    satWidth_e satW;
    logic [1:0] mrgByte;
    logic mrgEn;
    logic accEn;
    logic minEn;
    logic maxEn;
    logic satEn;
    logic dstSigned;
    logic ccEn;
    logic illegal;
  } strobe_t;

endpackage

// File: rtl/addsub_opsel.sv
module addsub_opsel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic [2:0]        fmt,
  input  logic [1:0]        sel,
  output logic [DATA_W:0]   ext
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int EXT_W  = DATA_W + 1;
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int NHALF  = DATA_W / HALF_W;

  logic [BYTE_W-1:0] byteLane [NBYTES];
  logic [HALF_W-1:0] halfLane [NHALF];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign byteLane[i] = word[i*BYTE_W +: BYTE_W];
  end
  for (genvar i = 0; i < NHALF; i++) begin : g_half
    assign halfLane[i] = word[i*HALF_W +: HALF_W];
  end

  logic              isSigned;
  logic [BYTE_W-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;

  assign isSigned = fmt[0];
  assign pickByte = byteLane[sel];
  assign pickHalf = halfLane[sel[0]];

  always_comb begin
    unique case (fmt[2:1])
      2'd1:    ext = {{(EXT_W-HALF_W){isSigned & pickHalf[HALF_W-1]}}, pickHalf};
      2'd2:    ext = {{(EXT_W-BYTE_W){isSigned & pickByte[BYTE_W-1]}}, pickByte};
      default: ext = {isSigned & word[DATA_W-1], word};
    endcase
  end
endmodule

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic       negA,
  input  logic       negB,
  input  logic       plusOne,
  input  logic [2:0] op2Sel,
  input  logic       satEn,
  input  logic       dstSigned,
  input  logic       ccEn,
  output strobe_t    st
);
  stage2Op_e op;
  logic      bad;

  assign op  = stage2Op_e'(op2Sel);
  assign bad = (negA & negB) | (plusOne & (negA | negB));

  always_comb begin
    st           = '0;
    st.illegal   = bad;
    st.satEn     = satEn;
    st.dstSigned = dstSigned;
    st.ccEn      = ccEn;

    if (bad)          st.addMode = AM_ADD;
    else if (negB)    st.addMode = AM_SUB_B;
    else if (negA)    st.addMode = AM_SUB_A;
    else if (plusOne) st.addMode = AM_INC;
    else              st.addMode = AM_ADD;

    st.satW = SW_FULL;
    unique case (op)
      OP_MRG_HI16: begin st.mrgEn = 1'b1; st.satW = SW_HALF; st.mrgByte = 2'd2; end
      OP_MRG_LO16: begin st.mrgEn = 1'b1; st.satW = SW_HALF; st.mrgByte = 2'd0; end
      OP_MRG_B0:   begin st.mrgEn = 1'b1; st.satW = SW_BYTE; st.mrgByte = 2'd0; end
      OP_MRG_B2:   begin st.mrgEn = 1'b1; st.satW = SW_BYTE; st.mrgByte = 2'd2; end
      OP_ACC:      st.accEn = 1'b1;
      OP_MIN:      st.minEn = 1'b1;
      OP_MAX:      st.maxEn = 1'b1;
      default:     ;
    endcase
  end
endmodule

// File: rtl/addsub_dpath.sv
module addsub_dpath
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcC,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              useImm,
  input  logic [2:0]        fmtA,
  input  logic [2:0]        fmtB,
  input  logic [1:0]        selA,
  input  logic [1:0]        selB,
  output logic              outValid,
  output logic [DATA_W-1:0] outRes,
  output logic              outZero,
  output logic              outNeg,
  output logic              outCarry,
  output logic              outOvf,
  output logic              outIllegal
);
  localparam int EXT_W  = DATA_W + 1;
  localparam int SUM_W  = DATA_W + 2;
  localparam int WIDE_W = DATA_W + 4;

  logic [EXT_W-1:0]  aExt, bRegExt, immExt, bExt, aOpd, bOpd;
  logic              carryIn;
  logic [SUM_W-1:0]  sumVal;
  logic [WIDE_W-1:0] cExt, wideVal, clampVal;
  logic [WIDE_W-1:0] unsMax, sgnMax, sgnMin;
  logic [7:0]        fieldBits;
  logic [DATA_W-1:0] fieldVal, fieldMask, laneMask, merged, resVal;
  logic [4:0]        mrgShift;
  logic              cmpLess;
  logic              zeroN, negN, carryN, ovfN;

  addsub_opsel #(.DATA_W(DATA_W)) u_selA (.word(srcA), .fmt(fmtA), .sel(selA), .ext(aExt));
  addsub_opsel #(.DATA_W(DATA_W)) u_selB (.word(srcB), .fmt(fmtB), .sel(selB), .ext(bRegExt));

  // immediate is extended first, negation comes after
  assign immExt = {{(EXT_W-IMM_W){fmtB[0] & immVal[IMM_W-1]}}, immVal};
  assign bExt   = useImm ? immExt : bRegExt;

  assign aOpd    = (st.addMode == AM_SUB_A) ? ~aExt : aExt;
  assign bOpd    = (st.addMode == AM_SUB_B) ? ~bExt : bExt;
  assign carryIn = (st.addMode != AM_ADD);
  assign sumVal  = {aOpd[EXT_W-1], aOpd} + {bOpd[EXT_W-1], bOpd} + SUM_W'(carryIn);

  assign cExt    = {{(WIDE_W-DATA_W){st.dstSigned & srcC[DATA_W-1]}}, srcC};
  assign wideVal = {{(WIDE_W-SUM_W){sumVal[SUM_W-1]}}, sumVal} + (st.accEn ? cExt : '0);

  always_comb begin
    unique case (st.satW)
      SW_HALF: fieldBits = 8'd16;
      SW_BYTE: fieldBits = 8'd8;
      default: fieldBits = 8'(DATA_W);
    endcase
  end

  assign unsMax = (WIDE_W'(1) << fieldBits) - WIDE_W'(1);
  assign sgnMax = (WIDE_W'(1) << (fieldBits - 8'd1)) - WIDE_W'(1);
  assign sgnMin = ~sgnMax;

  always_comb begin
    clampVal = wideVal;
    if (st.satEn) begin
      if (st.dstSigned) begin
        if ($signed(wideVal) > $signed(sgnMax))      clampVal = sgnMax;
        else if ($signed(wideVal) < $signed(sgnMin)) clampVal = sgnMin;
      end else begin
        if (wideVal[WIDE_W-1])     clampVal = '0;
        else if (wideVal > unsMax) clampVal = unsMax;
      end
    end
  end

  assign fieldVal  = clampVal[DATA_W-1:0];
  assign fieldMask = unsMax[DATA_W-1:0];
  assign mrgShift  = {st.mrgByte, 3'b000};
  assign laneMask  = fieldMask << mrgShift;
  assign merged    = (srcC & ~laneMask) | ((fieldVal << mrgShift) & laneMask);

  assign cmpLess = st.dstSigned ? ($signed(fieldVal) < $signed(srcC)) : (fieldVal < srcC);

  always_comb begin
    if (st.mrgEn)      resVal = merged;
    else if (st.minEn) resVal = cmpLess ? fieldVal : srcC;
    else if (st.maxEn) resVal = cmpLess ? srcC : fieldVal;
    else               resVal = fieldVal;
  end

  assign zeroN  = st.ccEn & (resVal == '0);
  assign negN   = st.ccEn & resVal[DATA_W-1];
  assign carryN = st.ccEn & (wideVal[WIDE_W-1:DATA_W] != '0);
  assign ovfN   = st.ccEn & (wideVal[WIDE_W-1:DATA_W-1] != '0)
                          & (wideVal[WIDE_W-1:DATA_W-1] != '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outRes     <= '0;
      outZero    <= 1'b0;
      outNeg     <= 1'b0;
      outCarry   <= 1'b0;
      outOvf     <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      outValid   <= inValid;
      outRes     <= resVal;
      outZero    <= zeroN;
      outNeg     <= negN;
      outCarry   <= carryN;
      outOvf     <= ovfN;
      outIllegal <= st.illegal;
    end
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcC,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              useImm,
  input  logic [2:0]        fmtA,
  input  logic [2:0]        fmtB,
  input  logic [1:0]        selA,
  input  logic [1:0]        selB,
  input  logic              negA,
  input  logic              negB,
  input  logic              plusOne,
  input  logic [2:0]        op2Sel,
  input  logic              satEn,
  input  logic              dstSigned,
  input  logic              ccEn,
  output logic              outValid,
  output logic [DATA_W-1:0] outRes,
  output logic              outZero,
  output logic              outNeg,
  output logic              outCarry,
  output logic              outOvf,
  output logic              outIllegal
);
  strobe_t st;

  addsub_ctrl u_ctrl (
    .negA(negA), .negB(negB), .plusOne(plusOne), .op2Sel(op2Sel),
    .satEn(satEn), .dstSigned(dstSigned), .ccEn(ccEn), .st(st)
  );

  addsub_dpath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dpath (
    .clk(clk), .rstN(rstN), .inValid(inValid), .st(st),
    .srcA(srcA), .srcB(srcB), .srcC(srcC), .immVal(immVal), .useImm(useImm),
    .fmtA(fmtA), .fmtB(fmtB), .selA(selA), .selB(selB),
    .outValid(outValid), .outRes(outRes), .outZero(outZero), .outNeg(outNeg),
    .outCarry(outCarry), .outOvf(outOvf), .outIllegal(outIllegal)
  );
endmodule

// File: rtl/addsub_chk.sv
module addsub_chk
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] srcC,
  input logic              negA,
  input logic              negB,
  input logic [2:0]        op2Sel,
  input logic              dstSigned,
  input logic              ccEn,
  input logic              outValid,
  input logic [DATA_W-1:0] outRes,
  input logic              outZero,
  input logic              outNeg,
  input logic              outCarry,
  input logic              outOvf,
  input logic              outIllegal
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R1
  AST_DOUBLE_NEG: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && negA && negB) |=> outIllegal); // R5
  AST_MRG_HI_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op2Sel == OP_MRG_HI16) |=> outRes[15:0] == $past(srcC[15:0])); // R7
  AST_MRG_B2_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op2Sel == OP_MRG_B2) |=>
      (outRes[15:0] == $past(srcC[15:0])) && (outRes[31:24] == $past(srcC[31:24]))); // R7
  AST_MIN_SIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op2Sel == OP_MIN && dstSigned) |=> $signed(outRes) <= $signed($past(srcC))); // R9
  AST_MAX_UNSIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op2Sel == OP_MAX && !dstSigned) |=> outRes >= $past(srcC)); // R9
  AST_FLAGS_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ccEn) |=> !(outZero || outNeg || outCarry || outOvf)); // R11
endmodule

bind addsub_unit addsub_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .srcC(srcC), .negA(negA), .negB(negB),
  .op2Sel(op2Sel), .dstSigned(dstSigned), .ccEn(ccEn), .outValid(outValid),
  .outRes(outRes), .outZero(outZero), .outNeg(outNeg), .outCarry(outCarry),
  .outOvf(outOvf), .outIllegal(outIllegal)
);

// File: tb/sim_addsub_unit.sv
module sim_addsub_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic [31:0] a, b, c;
    logic [15:0] imm;
    logic        useImm;
    logic [2:0]  fa, fb;
    logic [1:0]  sa, sb;
    logic        na, nb, po;
    logic [2:0]  op;
    logic        sat, ds, cc;
  } stim_t;

  typedef struct packed {
    stim_t       s;
    logic [31:0] exp;
  } vec_t;

  // fields: a, b, c, imm, useImm, fa, fb, sa, sb, na, nb, po, op, sat, ds, cc
  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{'{32'd5, 32'd7, 32'd0, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0}, 32'd12},
    '{'{32'd10, 32'd0, 32'd0, 16'hFFFF, 1'b1, 3'd0, 3'd3, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0}, 32'd11},
    '{'{32'd10, 32'd0, 32'd0, 16'hFFFF, 1'b1, 3'd0, 3'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0}, 32'd9},
    '{'{32'd10, 32'd0, 32'd0, 16'hFFFF, 1'b1, 3'd0, 3'd2, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0}, 32'hFFFF000B},
    '{'{32'h11223344, 32'hAABBCCDD, 32'd0, 16'h0, 1'b0, 3'd4, 3'd4, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}, 32'h000000DD},
    '{'{32'h000000F0, 32'd5, 32'd0, 16'h0, 1'b0, 3'd5, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0}, 32'hFFFFFFF5},
    '{'{32'd3, 32'd10, 32'd0, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0}, 32'd7},
    '{'{32'd4, 32'd5, 32'd0, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0}, 32'd10},
    '{'{32'h7000, 32'h2000, 32'h12345678, 16'h0, 1'b0, 3'd1, 3'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0}, 32'h7FFF5678},
    '{'{32'd2, 32'd5, 32'hAABBCCDD, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0}, 32'hAABBCC00},
    '{'{32'd1, 32'd2, 32'hFFFFFFFF, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0}, 32'd2},
    '{'{32'd1, 32'd2, 32'hFFFFFFFF, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0}, 32'hFFFFFFFF},
    '{'{32'd5, 32'd0, 32'hFFFFFFFE, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd6, 1'b0, 1'b1, 1'b0}, 32'hFFFFFFFE},
    '{'{32'd5, 32'd0, 32'hFFFFFFFE, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0}, 32'hFFFFFFFE},
    '{'{32'd5, 32'd0, 32'hFFFFFFFE, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd6, 1'b0, 1'b0, 1'b0}, 32'd5},
    '{'{32'h1FF, 32'd1, 32'h11223344, 16'h0, 1'b0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0}, 32'h11003344}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  stim_t cur = '0;
  logic [31:0] outRes;
  logic outValid, outZero, outNeg, outCarry, outOvf, outIllegal;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .srcA(cur.a), .srcB(cur.b), .srcC(cur.c), .immVal(cur.imm), .useImm(cur.useImm),
    .fmtA(cur.fa), .fmtB(cur.fb), .selA(cur.sa), .selB(cur.sb),
    .negA(cur.na), .negB(cur.nb), .plusOne(cur.po), .op2Sel(cur.op),
    .satEn(cur.sat), .dstSigned(cur.ds), .ccEn(cur.cc),
    .outValid(outValid), .outRes(outRes), .outZero(outZero), .outNeg(outNeg),
    .outCarry(outCarry), .outOvf(outOvf), .outIllegal(outIllegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint pick(input logic [31:0] w, input logic [2:0] f, input logic [1:0] s);
    logic [31:0] x;
    case (f[2:1])
      2'd1: begin
        x = s[0] ? (w >> 16) : w;
        return f[0] ? longint'($signed(x[15:0])) : longint'(x[15:0]);
      end
      2'd2: begin
        x = w >> (8 * s);
        return f[0] ? longint'($signed(x[7:0])) : longint'(x[7:0]);
      end
      default: return f[0] ? longint'($signed(w)) : longint'(w);
    endcase
  endfunction

  // wide-integer model: returns {illegal, Z, N, C, V, result}
  function automatic logic [36:0] model(input stim_t s);
    longint a, b, c, wide, lim;
    logic na, nb, po, ill, less;
    logic [31:0] v, res, fm, lm;
    int w, off;
    logic z, n, cy, ov;
    a = pick(s.a, s.fa, s.sa);
    if (s.useImm) b = s.fb[0] ? longint'($signed(s.imm)) : longint'(s.imm);
    else b = pick(s.b, s.fb, s.sb);
    ill = (s.na && s.nb) || (s.po && (s.na || s.nb));
    na = s.na && !ill;
    nb = s.nb && !ill;
    po = s.po && !ill;
    wide = (na ? -a : a) + (nb ? -b : b) + (po ? 64'sd1 : 64'sd0);
    c = s.ds ? longint'($signed(s.c)) : longint'(s.c);
    if (s.op == 3'd5) wide = wide + c;
    cy = (wide < 0) || (wide > 64'sh0FFFFFFFF);
    ov = (wide < -64'sh80000000) || (wide > 64'sh7FFFFFFF);
    w = (s.op == 3'd1 || s.op == 3'd2) ? 16 : ((s.op == 3'd3 || s.op == 3'd4) ? 8 : 32);
    if (s.sat) begin
      if (s.ds) begin
        lim = (longint'(1) <<< (w - 1));
        if (wide > lim - 1) wide = lim - 1;
        if (wide < -lim) wide = -lim;
      end else begin
        lim = (longint'(1) <<< w);
        if (wide < 0) wide = 0;
        if (wide > lim - 1) wide = lim - 1;
      end
    end
    v = wide[31:0];
    less = s.ds ? ($signed(v) < $signed(s.c)) : (v < s.c);
    off = (s.op == 3'd1 || s.op == 3'd4) ? 16 : 0;
    fm = (w == 16) ? 32'h0000FFFF : 32'h000000FF;
    lm = fm << off;
    case (s.op)
      3'd1, 3'd2, 3'd3, 3'd4: res = (s.c & ~lm) | ((v << off) & lm);
      3'd6: res = less ? v : s.c;
      3'd7: res = less ? s.c : v;
      default: res = v;
    endcase
    z = s.cc && (res == 32'd0);
    n = s.cc && res[31];
    cy = s.cc && cy;
    ov = s.cc && ov;
    return {ill, z, n, cy, ov, res};
  endfunction

  task automatic apply(input stim_t s);
    @(negedge clk);
    cur = s;
    inValid = 1'b1;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] pickData(input int k, input logic [31:0] rnd);
    case (k % 6)
      0: return 32'h7FFFFFFF;
      1: return 32'h80000000;
      2: return 32'hFFFFFFFF;
      3: return 32'h0000FFFF;
      default: return rnd;
    endcase
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    stim_t s;
    logic [36:0] e;
    logic [31:0] rnd;
    int k;
    rnd = 32'h1234ABCD;
    k = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset valid", 64'(outValid), 64'd0);
    check("R1 reset result", 64'(outRes), 64'd0);
    check("R1 reset flags", 64'({outZero, outNeg, outCarry, outOvf, outIllegal}), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // directed table: R2 R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].s);
      check($sformatf("R2/R3/R4/R6/R7/R8/R9/R10 table[%0d]", i), 64'(outRes), 64'(VECS[i].exp));
      check("R1 valid latency", 64'(outValid), 64'd1);
    end

    // flags: R11 wrap to zero, all flags set except sign
    s = '0;
    s.a = 32'hFFFFFFFF; s.b = 32'd1; s.ds = 1'b1; s.cc = 1'b1;
    apply(s);
    check("R11 flags on", 64'({outZero, outNeg, outCarry, outOvf}), 64'b1011);
    s.cc = 1'b0;
    apply(s);
    check("R11 flags gated", 64'({outZero, outNeg, outCarry, outOvf}), 64'b0000);

    // R5: illegal combinations compute plain add
    s = '0;
    s.a = 32'd5; s.b = 32'd7; s.na = 1'b1; s.nb = 1'b1; s.ds = 1'b1;
    apply(s);
    check("R5 double negate flag", 64'(outIllegal), 64'd1);
    check("R5 double negate result", 64'(outRes), 64'd12);
    s.nb = 1'b0; s.po = 1'b1;
    apply(s);
    check("R5 negate with plus-one", 64'({outIllegal, outRes}), {31'd0, 1'b1, 32'd12});

    // R1: idle cycle drops valid
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    #1;
    check("R1 idle drops valid", 64'(outValid), 64'd0);

    // model sweep over formats, modes, second-stage ops, saturation, signedness
    for (int fa = 0; fa < 6; fa++) begin
      for (int fb = 0; fb < 6; fb++) begin
        for (int m = 0; m < 5; m++) begin
          for (int op = 0; op < 8; op++) begin
            for (int sd = 0; sd < 4; sd++) begin
              rnd = rnd ^ (rnd << 13);
              rnd = rnd ^ (rnd >> 17);
              rnd = rnd ^ (rnd << 5);
              s = '0;
              s.a = pickData(k, rnd);
              s.b = pickData(k + 2, {rnd[15:0], rnd[31:16]});
              s.c = pickData(k + 4, ~rnd);
              s.imm = (k % 3 == 0) ? 16'hFFFF : rnd[23:8];
              s.useImm = (k % 4 == 1);
              s.fa = 3'(fa);
              s.fb = 3'(fb);
              s.sa = rnd[1:0];
              s.sb = rnd[3:2];
              s.na = (m == 2) || (m == 4);
              s.nb = (m == 1) || (m == 4);
              s.po = (m == 3);
              s.op = 3'(op);
              s.sat = sd[0];
              s.ds = sd[1];
              s.cc = 1'b1;
              k++;
              apply(s);
              e = model(s);
              check("R2/R3/R4/R5/R7/R8/R9/R10/R11 sweep",
                    64'({outIllegal, outZero, outNeg, outCarry, outOvf, outRes}), 64'(e));
            end
          end
        end
      end
    end

    // R1: reset while busy clears outputs
    apply(VECS[0].s);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reset mid-run", 64'({outValid, outRes}), 64'd0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule